// File: doc/BRIEF.md
# Instruction Dispatch Readiness Checker

This block decides, in a single cycle, whether the front instruction of a candidate wave may be dispatched to execution in the next cycle. The caller presents the instruction's class code, a scalar/vector flag, and the next-cycle availability of every resource the classes can require: the scalar and vector ALUs, the global, scalar-memory and local issue units, their data buses, the coalescer, the outstanding-request limit, and the free space in the scalar and local request FIFOs together with the wave's pending read and write counts. The verdict comes out on `disp_rdy` combinationally in the same cycle.

Every check also feeds a bank of saturating stall-reason counters. Each condition that fails increments its own counter, so one check may count several reasons at once. A passing check increments a ready counter instead. Any counter can be read through a select port. A class code that the block does not recognise reports not-ready, counts nothing, and sets a sticky error flag that only reset clears.

Top module: `dispatch_ready_chk`

## Requirements
- R1: Class codes 0 (no-op), 1 (ALU), 2 (branch) and 3 (barrier) need `salu_rdy` when `inst_scalar` is 1 and `valu_rdy` when it is 0. A miss counts on counter 1 (scalar ALU) or counter 2 (vector ALU).
- R2: Class code 4 (end of program) needs `salu_rdy` only when scalar, and counts a miss on counter 1. A vector end of program is always ready.
- R3: Class code 5 with `inst_scalar`=0 (vector global memory) needs four conditions. Each one that is false counts on its own counter: `gm_issue_rdy` on counter 3, `gm_bus_rdy` on counter 4, `coal_rdy` on counter 5 and `reqs_ok` on counter 6.
- R4: Class code 5 with `inst_scalar`=1 (scalar memory) needs three conditions, each counting its own miss: `sm_issue_rdy` on counter 7, `sm_bus_rdy` on counter 8, and scalar FIFO room on counter 9. There is room when `spend_rd`+`spend_wr` is strictly less than `sfifo_space`.
- R5: Class code 6 with `inst_scalar`=0 (vector local memory) needs three conditions, each counting its own miss: `lm_issue_rdy` on counter 10, `lm_bus_rdy` on counter 11, and local FIFO room on counter 12. There is room when `lpend_rd`+`lpend_wr` is strictly less than `lfifo_space`.
- R6: Class code 7 with `inst_scalar`=0 (flat) needs five conditions, each counting its own miss: both issue units on counter 13, both buses on counter 14, `coal_rdy` on counter 15, `reqs_ok` on counter 16, and local FIFO room on counter 17.
- R7: When `chk_valid` is 1, each failing condition of the class adds exactly one to its counter in that check. `disp_rdy` is 1 exactly when the class is known and no condition fails, and then counter 0 is incremented.
- R8: Class codes 8 to 15, and codes 6 or 7 with `inst_scalar`=1, are unknown. They give `disp_rdy`=0, change no counter, and set `cls_err` from the next cycle until reset.
- R9: With `chk_valid`=0, `disp_rdy` is 0 and no counter changes.
- R10: A counter that holds its all-ones value stays there when incremented.
- R11: `cnt_val` shows the counter selected by `cnt_sel`. A select of 18 or more reads 0.
- R12: Synchronous active-low reset clears all counters and `cls_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | A check is requested this cycle |
| inst_scalar | input | 1 | Instruction is scalar (1) or vector (0) |
| inst_class | input | 4 | Instruction class code |
| salu_rdy | input | 1 | Scalar ALU free next cycle |
| valu_rdy | input | 1 | Vector ALU free next cycle |
| gm_issue_rdy | input | 1 | Global memory issue unit free |
| gm_bus_rdy | input | 1 | Vector-to-global bus free |
| coal_rdy | input | 1 | Coalescer can accept |
| reqs_ok | input | 1 | Outstanding-request limit not reached |
| sm_issue_rdy | input | 1 | Scalar memory issue unit free |
| sm_bus_rdy | input | 1 | Scalar-to-memory bus free |
| lm_issue_rdy | input | 1 | Local memory issue unit free |
| lm_bus_rdy | input | 1 | Vector-to-local bus free |
| sfifo_space | input | FW | Free entries in scalar request FIFO |
| spend_rd | input | FW | Wave's pending scalar reads |
| spend_wr | input | FW | Wave's pending scalar writes |
| lfifo_space | input | FW | Free entries in local request FIFO |
| lpend_rd | input | FW | Wave's pending local reads |
| lpend_wr | input | FW | Wave's pending local writes |
| cnt_sel | input | SEL_W | Counter read select |
| disp_rdy | output | 1 | Instruction may dispatch |
| cls_err | output | 1 | Sticky unknown-class flag |
| cnt_val | output | CNT_W | Selected counter value |

## Verification
The assertions check several rules on every cycle. An idle cycle leaves the counters unchanged. A ready verdict never coincides with a counted stall reason and never appears without a request. An unknown class is never ready and always raises the flag, and the flag never drops. A vector end of program is always ready, and a flat access is refused when its local bus is busy. Only the bench's scenarios can show that every single condition of every class lands on the right counter. They also show that several reasons count together, that counters saturate, that out-of-range reads give zero, and the exact readiness verdict for the full sweep of resource and FIFO-room combinations.

// File: rtl/dr_pkg.sv
// Package: class codes and stall-reason counter indices for the dispatch
// readiness checker. Assumes a 4-bit class code; codes 8..15 are undefined.
package dr_pkg;
    localparam logic [3:0] IC_NOP     = 4'd0;
    localparam logic [3:0] IC_ALU     = 4'd1;
    localparam logic [3:0] IC_BRANCH  = 4'd2;
    localparam logic [3:0] IC_BARRIER = 4'd3;
    localparam logic [3:0] IC_ENDPGM  = 4'd4;
    localparam logic [3:0] IC_GLOBAL  = 4'd5;
    localparam logic [3:0] IC_LOCAL   = 4'd6;
    localparam logic [3:0] IC_FLAT    = 4'd7;

    localparam int RS_READY   = 0;
    localparam int RS_SALU    = 1;
    localparam int RS_VALU    = 2;
    localparam int RS_GM_ISS  = 3;
    localparam int RS_GM_BUS  = 4;
    localparam int RS_GM_COAL = 5;
    localparam int RS_GM_REQ  = 6;
    localparam int RS_SM_ISS  = 7;
    localparam int RS_SM_BUS  = 8;
    localparam int RS_SM_FIFO = 9;
    localparam int RS_LM_ISS  = 10;
    localparam int RS_LM_BUS  = 11;
    localparam int RS_LM_FIFO = 12;
    localparam int RS_FL_ISS  = 13;
    localparam int RS_FL_BUS  = 14;
    localparam int RS_FL_COAL = 15;
    localparam int RS_FL_REQ  = 16;
    localparam int RS_FL_FIFO = 17;
    localparam int NR         = 18;
endpackage

// File: rtl/dr_reason_eval.sv
// Combinational class decoder: produces one hit bit per stall reason
// (bit 0 = ready) and a known-class flag. Assumes the inputs are stable
// for the cycle; it holds no state.
module dr_reason_eval #(
    parameter int FW = 6
) (
    input  logic                  inst_scalar,
    input  logic [3:0]            inst_class,
    input  logic                  salu_rdy,
    input  logic                  valu_rdy,
    input  logic                  gm_issue_rdy,
    input  logic                  gm_bus_rdy,
    input  logic                  coal_rdy,
    input  logic                  reqs_ok,
    input  logic                  sm_issue_rdy,
    input  logic                  sm_bus_rdy,
    input  logic                  lm_issue_rdy,
    input  logic                  lm_bus_rdy,
    input  logic [FW-1:0]         sfifo_space,
    input  logic [FW-1:0]         spend_rd,
    input  logic [FW-1:0]         spend_wr,
    input  logic [FW-1:0]         lfifo_space,
    input  logic [FW-1:0]         lpend_rd,
    input  logic [FW-1:0]         lpend_wr,
    output logic [dr_pkg::NR-1:0] hit,
    output logic                  known
);
    import dr_pkg::*;

    logic          s_room, l_room;
    logic [NR-1:0] fail;

    // FIFO room: pending reads plus writes must be below the free space
    always_comb begin
        s_room = ({1'b0, spend_rd} + {1'b0, spend_wr}) < {1'b0, sfifo_space};
        l_room = ({1'b0, lpend_rd} + {1'b0, lpend_wr}) < {1'b0, lfifo_space};
    end

    // Per-class conjunction of resource conditions, one fail bit each
    always_comb begin
        fail  = '0;
        known = 1'b1;
        case (inst_class)
            IC_NOP, IC_ALU, IC_BRANCH, IC_BARRIER: begin
                if (inst_scalar) fail[RS_SALU] = !salu_rdy;
                else             fail[RS_VALU] = !valu_rdy;
            end
            IC_ENDPGM: begin
                if (inst_scalar) fail[RS_SALU] = !salu_rdy;
            end
            IC_GLOBAL: begin
                if (inst_scalar) begin
                    fail[RS_SM_ISS]  = !sm_issue_rdy;
                    fail[RS_SM_BUS]  = !sm_bus_rdy;
                    fail[RS_SM_FIFO] = !s_room;
                end else begin
                    fail[RS_GM_ISS]  = !gm_issue_rdy;
                    fail[RS_GM_BUS]  = !gm_bus_rdy;
                    fail[RS_GM_COAL] = !coal_rdy;
                    fail[RS_GM_REQ]  = !reqs_ok;
                end
            end
            IC_LOCAL: begin
                if (inst_scalar) known = 1'b0;
                else begin
                    fail[RS_LM_ISS]  = !lm_issue_rdy;
                    fail[RS_LM_BUS]  = !lm_bus_rdy;
                    fail[RS_LM_FIFO] = !l_room;
                end
            end
            IC_FLAT: begin
                if (inst_scalar) known = 1'b0;
                else begin
                    fail[RS_FL_ISS]  = !(gm_issue_rdy && lm_issue_rdy);
                    fail[RS_FL_BUS]  = !(gm_bus_rdy && lm_bus_rdy);
                    fail[RS_FL_COAL] = !coal_rdy;
                    fail[RS_FL_REQ]  = !reqs_ok;
                    fail[RS_FL_FIFO] = !l_room;
                end
            end
            default: known = 1'b0;
        endcase
    end

    // Ready bit replaces bit 0 of the fail vector
    always_comb begin
        hit           = fail;
        hit[RS_READY] = known && (fail == '0);
    end
endmodule

// File: rtl/dr_sat_cnt.sv
// Saturating up-counter for one stall reason. Assumes inc is a
// single-cycle pulse per event; holds at all-ones.
module dr_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] val
);
    // Count events, stop at the maximum value
    always_ff @(posedge clk) begin
        if (!rst_n)                 val <= '0;
        else if (inc && val != '1)  val <= val + 1'b1;
    end
endmodule

// File: rtl/dispatch_ready_chk.sv
// Top: evaluates dispatch readiness of one instruction per cycle, counts
// stall reasons in saturating counters and flags unknown classes. Assumes
// the caller holds inputs stable around the clock edge.
module dispatch_ready_chk #(
    parameter int FW    = 6,
    parameter int CNT_W = 32,
    localparam int SEL_W = $clog2(dr_pkg::NR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic             inst_scalar,
    input  logic [3:0]       inst_class,
    input  logic             salu_rdy,
    input  logic             valu_rdy,
    input  logic             gm_issue_rdy,
    input  logic             gm_bus_rdy,
    input  logic             coal_rdy,
    input  logic             reqs_ok,
    input  logic             sm_issue_rdy,
    input  logic             sm_bus_rdy,
    input  logic             lm_issue_rdy,
    input  logic             lm_bus_rdy,
    input  logic [FW-1:0]    sfifo_space,
    input  logic [FW-1:0]    spend_rd,
    input  logic [FW-1:0]    spend_wr,
    input  logic [FW-1:0]    lfifo_space,
    input  logic [FW-1:0]    lpend_rd,
    input  logic [FW-1:0]    lpend_wr,
    input  logic [SEL_W-1:0] cnt_sel,
    output logic             disp_rdy,
    output logic             cls_err,
    output logic [CNT_W-1:0] cnt_val
);
    import dr_pkg::*;

    logic [NR-1:0]       hit_vec;
    logic                cls_known;
    logic [CNT_W-1:0]    cnt_arr [NR];
    logic [NR*CNT_W-1:0] cnt_flat;

    dr_reason_eval #(.FW(FW)) u_eval (
        .inst_scalar (inst_scalar),  .inst_class  (inst_class),
        .salu_rdy    (salu_rdy),     .valu_rdy    (valu_rdy),
        .gm_issue_rdy(gm_issue_rdy), .gm_bus_rdy  (gm_bus_rdy),
        .coal_rdy    (coal_rdy),     .reqs_ok     (reqs_ok),
        .sm_issue_rdy(sm_issue_rdy), .sm_bus_rdy  (sm_bus_rdy),
        .lm_issue_rdy(lm_issue_rdy), .lm_bus_rdy  (lm_bus_rdy),
        .sfifo_space (sfifo_space),  .spend_rd    (spend_rd),
        .spend_wr    (spend_wr),     .lfifo_space (lfifo_space),
        .lpend_rd    (lpend_rd),     .lpend_wr    (lpend_wr),
        .hit         (hit_vec),      .known       (cls_known)
    );

    // One saturating counter per reason, incremented on a valid check
    for (genvar g = 0; g < NR; g++) begin : g_cnt
        dr_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (chk_valid && hit_vec[g]),
            .val  (cnt_arr[g])
        );
        assign cnt_flat[g*CNT_W +: CNT_W] = cnt_arr[g];
    end

    // Verdict is only given for a requested check
    assign disp_rdy = chk_valid && hit_vec[RS_READY];

    // Sticky unknown-class flag
    always_ff @(posedge clk) begin
        if (!rst_n)                       cls_err <= 1'b0;
        else if (chk_valid && !cls_known) cls_err <= 1'b1;
    end

    // Counter read mux; out-of-range selects read zero
    always_comb begin
        cnt_val = '0;
        for (int i = 0; i < NR; i++)
            if (cnt_sel == SEL_W'(i)) cnt_val = cnt_arr[i];
    end
endmodule

// File: rtl/dr_chk_sva.sv
// Checker bound to dispatch_ready_chk: per-cycle properties over ports and
// the decoder-to-counter interface. Assumes synchronous active-low reset.
module dr_chk_sva #(
    parameter int NR    = 18,
    parameter int CNT_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                chk_valid,
    input logic                inst_scalar,
    input logic [3:0]          inst_class,
    input logic                lm_bus_rdy,
    input logic                disp_rdy,
    input logic                cls_err,
    input logic                known,
    input logic [NR-1:0]       hit,
    input logic [NR*CNT_W-1:0] cnt_flat
);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> cnt_flat == $past(cnt_flat));

    p_no_rdy_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        disp_rdy |-> chk_valid);

    p_rdy_no_reason_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_rdy |-> $countones(hit[NR-1:1]) == 0);

    p_unknown_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !known) |-> !disp_rdy ##1 cls_err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cls_err |=> cls_err);

    p_vec_endpgm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && inst_class == 4'd4 && !inst_scalar) |-> disp_rdy);

    p_flat_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && inst_class == 4'd7 && !inst_scalar && !lm_bus_rdy)
        |-> !disp_rdy);
endmodule

bind dispatch_ready_chk dr_chk_sva #(.NR(dr_pkg::NR), .CNT_W(CNT_W)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_valid  (chk_valid),
    .inst_scalar(inst_scalar),
    .inst_class (inst_class),
    .lm_bus_rdy (lm_bus_rdy),
    .disp_rdy   (disp_rdy),
    .cls_err    (cls_err),
    .known      (cls_known),
    .hit        (hit_vec),
    .cnt_flat   (cnt_flat)
);

// File: tb/sim_dispatch_ready_chk.sv
`timescale 1ns/1ps
module sim_dispatch_ready_chk;
    localparam int FW = 6;
    localparam int CW = 4;
    localparam int NRB = 18;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic chk_valid = 0, inst_scalar = 0;
    logic [3:0] inst_class = 0;
    logic salu_rdy = 0, valu_rdy = 0, gm_issue_rdy = 0, gm_bus_rdy = 0;
    logic coal_rdy = 0, reqs_ok = 0, sm_issue_rdy = 0, sm_bus_rdy = 0;
    logic lm_issue_rdy = 0, lm_bus_rdy = 0;
    logic [FW-1:0] sfifo_space = 0, spend_rd = 0, spend_wr = 0;
    logic [FW-1:0] lfifo_space = 0, lpend_rd = 0, lpend_wr = 0;
    logic [4:0] cnt_sel = 0;
    logic disp_rdy, cls_err;
    logic [CW-1:0] cnt_val;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int exp_cnt [NRB];
    bit exp_err = 0;

    always #10 clk = ~clk;

    dispatch_ready_chk #(.FW(FW), .CNT_W(CW)) u0 (.*);

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Expected reason bits from the requirement text; bit 0 = ready
    function automatic void model(input bit sc, input int cls, input logic [9:0] r,
                                  input bit sroom, input bit lroom,
                                  output bit [NRB-1:0] h, output bit kn);
        h = '0; kn = 1;
        if (cls <= 3) begin                               // R1
            if (sc) h[1] = !r[0]; else h[2] = !r[1];
        end else if (cls == 4) begin                      // R2
            if (sc) h[1] = !r[0];
        end else if (cls == 5 && !sc) begin               // R3
            h[3] = !r[2]; h[4] = !r[3]; h[5] = !r[4]; h[6] = !r[5];
        end else if (cls == 5) begin                      // R4
            h[7] = !r[6]; h[8] = !r[7]; h[9] = !sroom;
        end else if (cls == 6 && !sc) begin               // R5
            h[10] = !r[8]; h[11] = !r[9]; h[12] = !lroom;
        end else if (cls == 7 && !sc) begin               // R6
            h[13] = !(r[2] && r[8]); h[14] = !(r[3] && r[9]);
            h[15] = !r[4]; h[16] = !r[5]; h[17] = !lroom;
        end else kn = 0;                                  // R8
        h[0] = kn && (h[NRB-1:1] == '0);
    endfunction

    task automatic do_vec(input bit v, input bit sc, input int cls,
                          input logic [9:0] r, input int fk);
        bit [NRB-1:0] h; bit kn;
        @(negedge clk);
        chk_valid = v; inst_scalar = sc; inst_class = 4'(cls);
        {lm_bus_rdy, lm_issue_rdy, sm_bus_rdy, sm_issue_rdy, reqs_ok,
         coal_rdy, gm_bus_rdy, gm_issue_rdy, valu_rdy, salu_rdy} = r;
        sfifo_space = 2; spend_rd = fk[0] ? 0 : 1; spend_wr = 1;
        lfifo_space = 3; lpend_rd = fk[1] ? 1 : 2; lpend_wr = 1;
        model(sc, cls, r, fk[0], fk[1], h, kn);
        #2;
        check(disp_rdy == (v && h[0]), v ? "R7 verdict" : "R9 idle verdict",
              int'(disp_rdy), int'(v && h[0]));
        @(posedge clk);
        if (v) begin
            for (int i = 0; i < NRB; i++)
                if (h[i] && exp_cnt[i] < CMAX) exp_cnt[i]++;   // R10 saturation
            if (!kn) exp_err = 1;
        end
        #1;
        check(cls_err == exp_err, "R8 cls_err", int'(cls_err), int'(exp_err));
        for (int s = 0; s < NRB; s++) begin
            cnt_sel = 5'(s); #0.2;
            check(int'(cnt_val) == exp_cnt[s], "R7/R10 counter", int'(cnt_val), exp_cnt[s]);
        end
    endtask

    initial begin
        while (cycles < 190000) begin
            @(posedge clk); cycles++;
        end
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [9:0] lf;
        for (int i = 0; i < NRB; i++) exp_cnt[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check(disp_rdy == 0, "R12 disp_rdy", int'(disp_rdy), 0);
        check(cls_err == 0, "R12 cls_err", int'(cls_err), 0);
        for (int s = 0; s < NRB; s++) begin
            cnt_sel = 5'(s); #0.2;
            check(cnt_val == 0, "R12 counter", int'(cnt_val), 0);
        end
        @(negedge clk); rst_n = 1;

        // Directed: counting before saturation, multi-reason counts (R7)
        do_vec(1, 0, 5, 10'h000, 0);   // R3: four reasons at once
        do_vec(1, 0, 7, 10'h000, 0);   // R6: five reasons at once
        do_vec(1, 1, 5, 10'h0C0, 3);   // R4: ready
        do_vec(1, 1, 5, 10'h000, 0);   // R4: three reasons
        do_vec(1, 0, 6, 10'h300, 1);   // R5: fifo only
        do_vec(1, 0, 4, 10'h000, 0);   // R2: vector endpgm ready
        do_vec(1, 1, 4, 10'h000, 0);   // R2: scalar endpgm salu miss
        do_vec(0, 0, 5, 10'h000, 0);   // R9: idle, nothing counts
        lf = 10'h2A5;
        for (int k = 0; k < 40; k++) begin
            lf = {lf[8:0], lf[9] ^ lf[6]};
            do_vec(1, lf[0], int'(lf[3:1]), lf, int'(lf[5:4]));
        end

        // R12: reset clears, then exhaustive sweep with saturation (R1-R10)
        @(negedge clk); rst_n = 0; chk_valid = 0;
        @(posedge clk); #1;
        for (int i = 0; i < NRB; i++) exp_cnt[i] = 0;
        exp_err = 0;
        check(cls_err == 0, "R12 cls_err after reset", int'(cls_err), 0);
        @(negedge clk); rst_n = 1;
        for (int c = 0; c < 10; c++)
            for (int sc = 0; sc < 2; sc++)
                for (int fk = 0; fk < 4; fk++)
                    for (int r = 0; r < 1024; r++)
                        do_vec(((r ^ (fk * 37)) % 11) != 0, sc[0], c, 10'(r), fk);

        // R11: out-of-range selects read zero
        for (int s = NRB; s < 32; s++) begin
            cnt_sel = 5'(s); #0.2;
            check(cnt_val == 0, "R11 out-of-range read", int'(cnt_val), 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule